// File: doc/BRIEF.md
# I/Q Byte-to-Word Packer and Unpacker

This block sits between an 8-bit data converter port and a 32-bit word port that leads to a sample buffer. It uses one sample clock and handles one byte per clock. A direction input picks the mode. In receive mode the block collects four converter bytes into one word. The first byte goes into the lowest byte lane. The finished word is presented with a valid/ready handshake. In transmit mode the block takes a word over a valid/ready handshake and plays it out one byte per clock, lowest lane first.

I and Q bytes alternate on the same lanes. The byte counter always restarts at lane zero, so every I byte sits at an even lane. The `slot_q` output tells the converter side which component the current byte carries. The interrupt `irq_full` pulses when a receive word is completed. The interrupt `irq_empty` pulses when the transmit holding word is taken for playout. Two sticky flags record an overrun in receive and an underrun in transmit.

Top module: `iq_word_packer`

## Requirements
- R1: A synchronous active-high reset clears the following: the byte counter, both held words, `rx_valid`, `rx_word`, both interrupts and both sticky flags. `dac_byte` is 0 after reset.
- R2: In receive, the byte taken in lane slot k is placed in `rx_word` bits [8k+7:8k]. Slot 0 is the earliest byte. `rx_word` and `rx_valid` update in the cycle after the slot-3 byte is taken.
- R3: `slot_q` is 0 on even slots (I) and 1 on odd slots (Q). The first active byte after reset or after a direction change is always slot 0.
- R4: A cycle in which `dir_tx` differs from its value in the previous cycle is a restart cycle. In that cycle no byte is captured or emitted and `dac_byte` is 0. The counter returns to slot 0 and any partial word in either direction is dropped.
- R5: While `rx_valid` is 1 and `rx_ready` is 0, `rx_word` stays stable. An accept (`rx_valid` and `rx_ready` both 1) clears `rx_valid`, except when a new word completes in the same cycle.
- R6: If a word completes while the previous one is still held and not accepted, the new word replaces it. `ovr_flag` is then set and stays set until `flag_clr` is asserted.
- R7: `irq_full` is a one-cycle pulse in the cycle that a new `rx_word` first appears.
- R8: `tx_ready` is 1 when `dir_tx` is 1 and no word is held. A held word is taken at slot 0. Its lanes appear on `dac_byte` in slots 0 to 3 in the same cycle as the slot, lowest lane first.
- R9: `irq_empty` is a one-cycle pulse in the cycle after the held transmit word is taken at slot 0.
- R10: If no word is held at a transmit slot 0, all four slots of that word period drive 0. `udr_flag` is then set and stays set until `flag_clr` is asserted.
- R11: In receive mode `dac_byte` is 0. `flag_clr` clears both flags. A set event in the same cycle as `flag_clr` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one byte per cycle |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | 0 selects receive, 1 selects transmit |
| adc_byte | input | 8 | Byte from the converter in receive |
| dac_byte | output | 8 | Byte to the converter in transmit |
| slot_q | output | 1 | Current slot carries Q (1) or I (0) |
| rx_word | output | 32 | Packed receive word |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Buffer side accepts the receive word |
| tx_word | input | 32 | Transmit word from the buffer side |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken |
| flag_clr | input | 1 | Clears the sticky flags |
| irq_full | output | 1 | Receive word completed pulse |
| irq_empty | output | 1 | Transmit holding word taken pulse |
| ovr_flag | output | 1 | Sticky receive overrun |
| udr_flag | output | 1 | Sticky transmit underrun |

## Verification
Several properties are checked by the assertions on every cycle:
- the counter restarts after a direction change;
- `dac_byte` stays silent in receive mode and in restart cycles;
- a held receive word is stable while it waits;
- both flags are sticky;
- an accepted transmit word closes `tx_ready`;
- `irq_full` never pulses without a valid word.

Other properties can only be shown by the bench scenarios, which compare against a queue-based model on every clock:
- the byte order inside words;
- I/Q lane parity across mid-word direction switches;
- the replacement word after an overrun;
- the zero-filled word period on a starved transmit side.

// File: rtl/iq_pack_pkg.sv
package iq_pack_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } pack_dir_e;

  // Bit offset of a byte lane inside a word.
  function automatic int lane_lsb(input int idx, input int bytew);
    return idx * bytew;
  endfunction
endpackage

// File: rtl/iq_slot_ctrl.sv
module iq_slot_ctrl #(
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_tx,
  output logic [CW-1:0] slot,
  output logic          dir_chg,
  output logic          rx_act,
  output logic          tx_act,
  output logic          last_slot
);
  import iq_pack_pkg::*;

  pack_dir_e dir_q;

  assign dir_chg   = (pack_dir_e'(dir_tx) != dir_q);
  assign rx_act    = (pack_dir_e'(dir_tx) == DIR_RX) && !dir_chg;
  assign tx_act    = (pack_dir_e'(dir_tx) == DIR_TX) && !dir_chg;
  assign last_slot = (slot == CW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RX;
      slot  <= '0;
    end else begin
      dir_q <= pack_dir_e'(dir_tx);
      if (dir_chg || last_slot) slot <= '0;
      else                      slot <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/iq_rx_pack.sv
module iq_rx_pack #(
  parameter int SMP_W = 8,
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES),
  localparam int WORD_W = SMP_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              dir_chg,
  input  logic [CW-1:0]     slot,
  input  logic              last_slot,
  input  logic [SMP_W-1:0]  byte_in,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic              done,
  output logic              ovr_set
);
  import iq_pack_pkg::*;

  logic [WORD_W-1:0] asm_w;

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    logic [SMP_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || dir_chg)                 lane_q <= '0;
      else if (act && slot == CW'(g))     lane_q <= byte_in;
    end
    assign asm_w[lane_lsb(g, SMP_W) +: SMP_W] = lane_q;
  end
  assign asm_w[WORD_W-1 -: SMP_W] = byte_in;

  assign done    = act && last_slot;
  assign ovr_set = done && valid && !rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      valid <= 1'b0;
    end else if (done) begin
      word  <= asm_w;
      valid <= 1'b1;
    end else if (valid && rd_ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_tx_unpack.sv
module iq_tx_unpack #(
  parameter int SMP_W = 8,
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES),
  localparam int WORD_W = SMP_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              dir_chg,
  input  logic              tx_mode,
  input  logic [CW-1:0]     slot,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [SMP_W-1:0]  byte_out,
  output logic              load,
  output logic              udr_set
);
  import iq_pack_pkg::*;

  logic [WORD_W-1:0] hold_q, cur_q;
  logic              hold_v, cur_v;
  logic              at_first;

  function automatic logic [SMP_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                               input logic [CW-1:0] s);
    return w[lane_lsb(int'(s), SMP_W) +: SMP_W];
  endfunction

  assign wr_ready = tx_mode && !hold_v;
  assign at_first = act && (slot == '0);
  assign load     = at_first && hold_v;
  assign udr_set  = at_first && !hold_v;

  always_comb begin
    if (!act)              byte_out = '0;
    else if (slot == '0)   byte_out = hold_v ? hold_q[SMP_W-1:0] : '0;
    else                   byte_out = cur_v ? lane_of(cur_q, slot) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      cur_q  <= '0;
      cur_v  <= 1'b0;
    end else begin
      if (dir_chg) begin
        cur_v <= 1'b0;
      end else if (at_first) begin
        cur_v <= hold_v;
        if (hold_v) cur_q <= hold_q;
      end
      if (load) hold_v <= 1'b0;
      if (wr_valid && wr_ready) begin
        hold_q <= wr_word;
        hold_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_word_packer.sv
module iq_word_packer #(
  parameter int SMP_W = 8,
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES),
  localparam int WORD_W = SMP_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_tx,
  input  logic [SMP_W-1:0]  adc_byte,
  output logic [SMP_W-1:0]  dac_byte,
  output logic              slot_q,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              flag_clr,
  output logic              irq_full,
  output logic              irq_empty,
  output logic              ovr_flag,
  output logic              udr_flag
);
  // Named internal events, also observed by the bound checker.
  logic [CW-1:0] slot;
  logic          dir_chg, rx_act, tx_act, last_slot;
  logic          rx_done, ovr_set, tx_load, udr_set;

  iq_slot_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .dir_tx(dir_tx), .slot(slot), .dir_chg(dir_chg),
    .rx_act(rx_act), .tx_act(tx_act), .last_slot(last_slot)
  );

  iq_rx_pack #(.SMP_W(SMP_W), .LANES(LANES)) u_rx (
    .clk(clk), .rst(rst), .act(rx_act), .dir_chg(dir_chg), .slot(slot),
    .last_slot(last_slot), .byte_in(adc_byte), .rd_ready(rx_ready),
    .word(rx_word), .valid(rx_valid), .done(rx_done), .ovr_set(ovr_set)
  );

  iq_tx_unpack #(.SMP_W(SMP_W), .LANES(LANES)) u_tx (
    .clk(clk), .rst(rst), .act(tx_act), .dir_chg(dir_chg), .tx_mode(dir_tx),
    .slot(slot), .wr_word(tx_word), .wr_valid(tx_valid), .wr_ready(tx_ready),
    .byte_out(dac_byte), .load(tx_load), .udr_set(udr_set)
  );

  assign slot_q = slot[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_full  <= 1'b0;
      irq_empty <= 1'b0;
      ovr_flag  <= 1'b0;
      udr_flag  <= 1'b0;
    end else begin
      irq_full  <= rx_done;
      irq_empty <= tx_load;
      ovr_flag  <= ovr_set | (ovr_flag & ~flag_clr);
      udr_flag  <= udr_set | (udr_flag & ~flag_clr);
    end
  end
endmodule

// File: rtl/iq_word_packer_chk.sv
module iq_word_packer_chk #(
  parameter int SMP_W = 8,
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES),
  localparam int WORD_W = SMP_W * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              dir_tx,
  input logic [SMP_W-1:0]  dac_byte,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              flag_clr,
  input logic              irq_full,
  input logic              ovr_flag,
  input logic              udr_flag,
  input logic              dir_chg,
  input logic              rx_done,
  input logic [CW-1:0]     slot
);
  a_r4_restart_slot: assert property (@(posedge clk) disable iff (rst)
    dir_chg |=> (slot == '0));

  a_r4_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    dir_chg |-> (dac_byte == '0));

  a_r11_rx_silent: assert property (@(posedge clk) disable iff (rst)
    !dir_tx |-> (dac_byte == '0));

  a_r5_word_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !rx_done) |=> (rx_valid && $stable(rx_word)));

  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !flag_clr) |=> ovr_flag);

  a_r10_udr_sticky: assert property (@(posedge clk) disable iff (rst)
    (udr_flag && !flag_clr) |=> udr_flag);

  a_r7_irq_has_word: assert property (@(posedge clk) disable iff (rst)
    irq_full |-> rx_valid);

  a_r8_accept_closes: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind iq_word_packer iq_word_packer_chk #(.SMP_W(SMP_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .dir_tx(dir_tx), .dac_byte(dac_byte),
  .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .flag_clr(flag_clr),
  .irq_full(irq_full), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
  .dir_chg(dir_chg), .rx_done(rx_done), .slot(slot)
);

// File: tb/iq_word_packer_bench.sv
module iq_word_packer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dir_tx = 1'b0;
  logic [7:0]  adc_byte = 8'h10;
  logic [7:0]  dac_byte;
  logic        slot_q;
  logic [31:0] rx_word;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [31:0] tx_word = 32'h83828180;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic        flag_clr = 1'b0;
  logic        irq_full, irq_empty, ovr_flag, udr_flag;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  iq_word_packer u_iq_word_packer (
    .clk(clk), .rst(rst), .dir_tx(dir_tx), .adc_byte(adc_byte),
    .dac_byte(dac_byte), .slot_q(slot_q), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_word(tx_word),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .flag_clr(flag_clr),
    .irq_full(irq_full), .irq_empty(irq_empty), .ovr_flag(ovr_flag),
    .udr_flag(udr_flag)
  );

  // Behavioural reference model
  int          m_cnt;
  bit          m_dirq, m_rxv, m_irqf, m_irqe, m_ovr, m_udr;
  logic [31:0] m_rxw;
  logic [7:0]  rxq[$];
  logic [7:0]  play[$];
  logic [31:0] hq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_dirq = 0; m_rxv = 0; m_irqf = 0; m_irqe = 0;
      m_ovr = 0; m_udr = 0; m_rxw = 0;
      rxq.delete(); play.delete(); hq.delete();
    end else begin
      bit chg, acc_tx, fin;
      chg    = (dir_tx != m_dirq);
      acc_tx = dir_tx && tx_valid && (hq.size() == 0);
      fin    = 0;
      m_irqf = 0; m_irqe = 0;
      if (flag_clr) begin m_ovr = 0; m_udr = 0; end
      if (chg) begin
        rxq.delete(); play.delete(); m_cnt = 0;
      end else if (!dir_tx) begin
        rxq.push_back(adc_byte);
        if (rxq.size() == 4) begin
          fin = 1;
          if (m_rxv && !rx_ready) m_ovr = 1;
          m_rxw = {rxq[3], rxq[2], rxq[1], rxq[0]};
          rxq.delete();
          m_irqf = 1;
        end
        m_cnt = (m_cnt + 1) % 4;
      end else begin
        if (m_cnt == 0) begin
          if (hq.size() != 0) begin
            logic [31:0] w;
            w = hq.pop_front();
            play.delete();
            play.push_back(w[15:8]); play.push_back(w[23:16]); play.push_back(w[31:24]);
            m_irqe = 1;
          end else begin
            play.delete();
            repeat (3) play.push_back(8'h00);
            m_udr = 1;
          end
        end else if (play.size() != 0) begin
          void'(play.pop_front());
        end
        m_cnt = (m_cnt + 1) % 4;
      end
      if (fin) m_rxv = 1;
      else if (m_rxv && rx_ready) m_rxv = 0;
      if (acc_tx) begin
        hq.push_back(tx_word);
        tx_word <= tx_word + 32'h04040404;
      end
      m_dirq = dir_tx;
    end
    adc_byte <= adc_byte + 8'd7;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit chg;
    logic [7:0] e_dac;
    chg = (dir_tx != m_dirq);
    if (!dir_tx || chg)   e_dac = 8'h00;
    else if (m_cnt == 0)  e_dac = (hq.size() != 0) ? hq[0][7:0] : 8'h00;
    else                  e_dac = (play.size() != 0) ? play[0] : 8'h00;
    chk(dac_byte === e_dac, chg ? "R4" : (!dir_tx ? "R11" : "R8"), "dac_byte", 32'(dac_byte), 32'(e_dac));
    chk(slot_q === m_cnt[0], "R3", "slot_q", 32'(slot_q), 32'(m_cnt[0]));
    chk(rx_word === m_rxw, "R2", "rx_word", rx_word, m_rxw);
    chk(rx_valid === m_rxv, "R5", "rx_valid", 32'(rx_valid), 32'(m_rxv));
    chk(tx_ready === (dir_tx && hq.size() == 0), "R8", "tx_ready", 32'(tx_ready),
        32'(dir_tx && hq.size() == 0));
    chk(irq_full === m_irqf, "R7", "irq_full", 32'(irq_full), 32'(m_irqf));
    chk(irq_empty === m_irqe, "R9", "irq_empty", 32'(irq_empty), 32'(m_irqe));
    chk(ovr_flag === m_ovr, "R6", "ovr_flag", 32'(ovr_flag), 32'(m_ovr));
    chk(udr_flag === m_udr, "R10", "udr_flag", 32'(udr_flag), 32'(m_udr));
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      #1 compare();
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    #1;
    chk(rx_valid === 1'b0 && rx_word === 32'h0, "R1", "rx after reset", rx_word, 32'h0);
    chk(irq_full === 1'b0 && irq_empty === 1'b0, "R1", "irqs after reset",
        32'({irq_full, irq_empty}), 32'h0);
    chk(ovr_flag === 1'b0 && udr_flag === 1'b0, "R1", "flags after reset",
        32'({ovr_flag, udr_flag}), 32'h0);
    chk(dac_byte === 8'h00 && tx_ready === 1'b0, "R1", "tx side after reset",
        32'({dac_byte, tx_ready}), 32'h0);
    // R2: receive with a ready buffer
    rx_ready = 1'b1;
    tick(20);
    // R6: stalled buffer causes overrun, then clear
    rx_ready = 1'b0;
    tick(13);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    rx_ready = 1'b1;
    tick(9);
    // R4: switch to transmit mid-word with words available (R8, R9)
    tick(2);
    dir_tx = 1'b1; tx_valid = 1'b1;
    tick(40);
    // R10: starve the transmit side
    tx_valid = 1'b0;
    tick(14);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    tx_valid = 1'b1;
    tick(11);
    // back to receive mid-word, irregular ready pattern (R5)
    dir_tx = 1'b0;
    for (int i = 0; i < 40; i++) begin
      rx_ready = (i % 3) != 0;
      tick(1);
    end
    // quick direction toggles (R3, R4)
    for (int i = 0; i < 6; i++) begin
      dir_tx = ~dir_tx;
      tick(3 + i);
    end
    dir_tx = 1'b0;
    rx_ready = 1'b0;
    tick(12);
    // R11: clear while a new overrun sets in the same cycle
    flag_clr = 1'b1; tick(4); flag_clr = 1'b0;
    tick(4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule